// File: doc/BRIEF.md
# FSK Byte Framer Host Interface

This block sits behind an FSK demodulator that delivers a 1200 bit/s asynchronous serial stream, already sampled into the system clock. It finds each character (one low start bit, eight data bits sent least significant bit first, one high stop bit) and presents it to a small microcontroller over three wires: a data line, a data clock and an active-low ready line. The host does not need a UART, and it does not need to recover the bit timing in software.

A mode pin picks between two host protocols. With the pin low (bit-stream mode), the serial input goes straight through to the data line. The block drives the data clock with one rising edge in the centre of each data bit and pulses ready low for half a bit at the start of the stop bit, so the host only has to save a bit on each clock edge. With the pin high (buffered mode), the eight data bits and the stop bit are stored in a nine-bit holding register. Ready stays low until the host has clocked all nine bits out through the data clock line, which becomes an input in this mode.

Bit timing comes from a tick at sixteen times the bit rate. The tick is restarted at each candidate start edge. A framing state machine has four states. IDLE goes to START when the line is seen low. START returns to IDLE if the line is high again at the middle of the start bit (a false start), and otherwise moves to DATA. DATA samples one bit at each bit centre and moves to STOP after the eighth. STOP goes back to IDLE at the centre of the stop bit, and it hands the nine-bit word to the holding register at that point.

Top module: `fsk_byte_framer`

## Requirements
- R1: After reset, with the mode pin low and the serial input high, ready is high, the data clock output is low, the data clock output enable is high and the data line is high.
- R2: In bit-stream mode, the data line equals the serial input in the same cycle.
- R3: In bit-stream mode, each accepted character gives exactly eight rising edges on the data clock. No rising edge comes during the start bit or the stop bit. The data line seen at the k-th rising edge is data bit k-1, least significant bit first.
- R4: In bit-stream mode, every data clock high phase lasts half a nominal bit (8 ticks, which is 8×DIV clock cycles).
- R5: In bit-stream mode, ready falls half a bit (8×DIV cycles) after the eighth data clock rising edge. That is the start of the stop bit. Ready then stays low for exactly half a bit.
- R6: A low level shorter than half a bit that is high again at the mid-start-bit resample gives no data clock edge and no ready pulse.
- R7: In buffered mode, ready goes low once a character has been stored. It stays low through the first eight host clock rising edges and goes high on the ninth.
- R8: In buffered mode, each host clock rising edge puts the next stored bit on the data line: data bit 0 first, data bit 7 eighth, and the received stop bit ninth. A stop bit received as 0 is delivered as 0.
- R9: In buffered mode, the data clock output enable is low and the data clock output is held low.
- R10: In buffered mode, a character that completes while an earlier one is partly read replaces it, and the next host edge starts again from data bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsk_bit | input | 1 | Demodulated serial bit, synchronous to clk, idle high |
| buf_mode | input | 1 | 0 = bit-stream mode, 1 = buffered mode |
| host_clk | input | 1 | Host shift clock used in buffered mode, synchronous to clk |
| data_out | output | 1 | Data line to the host |
| dclk_out | output | 1 | Data clock driven in bit-stream mode |
| dclk_oe | output | 1 | High when the block drives the data clock pin |
| rdy_n | output | 1 | Active-low data ready |

## Verification
The bench sends random characters in bit-stream mode and measures the data clock high width, the gap from the eighth clock edge to ready, and the ready width. A design whose tick phase is off by one would show a width or a gap that misses 8×DIV cycles, and one that clocks the start or stop bit would show nine or ten edges. A short low glitch checks the mid-start resample: a design without it would clock out a byte of ones. In buffered mode the bench reads back random words, a word whose stop bit is 0, and a word that replaces one left half read. A buffer that drops the stop bit, raises ready one read early, or keeps its read position after a reload returns the wrong nine bits.

// File: rtl/fsk_framer_pkg.sv
package fsk_framer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } frm_state_t;
endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = !hold && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (hold || cnt_q == CNT_LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/fsk_frame_fsm.sv
module fsk_frame_fsm
    import fsk_framer_pkg::*;
#(
    parameter int SUBS      = 16,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_bit,
    output logic                 tick_hold,
    output logic                 dclk_q,
    output logic                 rdy_pulse,
    output logic                 load,
    output logic [DATA_BITS:0]   word
);
    localparam int SW = $clog2(SUBS);
    localparam int IW = $clog2(DATA_BITS);
    localparam logic [SW-1:0] SUB_HALF = SW'(SUBS / 2 - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUBS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

    frm_state_t           state_q, state_d;
    logic [SW-1:0]        sub_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 at_mid, at_edge;

    assign at_mid    = tick && (sub_q == SUB_LAST);
    assign at_edge   = tick && (sub_q == SUB_HALF);
    assign tick_hold = (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!rx_bit) state_d = ST_START;
            ST_START: if (at_edge) state_d = rx_bit ? ST_IDLE : ST_DATA;
            ST_DATA:  if (at_mid && idx_q == IDX_LAST) state_d = ST_STOP;
            ST_STOP:  if (at_mid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            dclk_q    <= 1'b0;
            rdy_pulse <= 1'b0;
            load      <= 1'b0;
            word      <= '0;
        end else begin
            load <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    sub_q <= '0;
                end
                ST_START: begin
                    if (at_edge) begin
                        sub_q <= '0;
                        idx_q <= '0;
                    end else if (tick) begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (tick) sub_q <= sub_q + 1'b1;
                    if (at_mid) begin
                        shreg_q <= {rx_bit, shreg_q[DATA_BITS-1:1]};
                        idx_q   <= idx_q + 1'b1;
                        dclk_q  <= 1'b1;
                    end else if (at_edge) begin
                        dclk_q <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (tick) sub_q <= sub_q + 1'b1;
                    if (at_edge) begin
                        dclk_q    <= 1'b0;
                        rdy_pulse <= 1'b1;
                    end else if (at_mid) begin
                        rdy_pulse <= 1'b0;
                        load      <= 1'b1;
                        word      <= {rx_bit, shreg_q};
                    end
                end
                default: sub_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/fsk_hold_buf.sv
module fsk_hold_buf #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         host_rise,
    output logic         bit_out,
    output logic         full
);
    localparam int LW = $clog2(W + 1);
    localparam logic [LW-1:0] LEFT_ALL = LW'(W);

    logic [W-1:0]  sh_q;
    logic [LW-1:0] left_q;

    assign full = (left_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q    <= '0;
            left_q  <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            sh_q   <= word;
            left_q <= LEFT_ALL;
        end else if (host_rise && full) begin
            bit_out <= sh_q[0];
            sh_q    <= sh_q >> 1;
            left_q  <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/fsk_byte_framer.sv
module fsk_byte_framer #(
    parameter int DIV       = 4,
    parameter int SUBS      = 16,
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsk_bit,
    input  logic buf_mode,
    input  logic host_clk,
    output logic data_out,
    output logic dclk_out,
    output logic dclk_oe,
    output logic rdy_n
);
    localparam int WORD_W = DATA_BITS + 1;

    logic              tick, tick_hold;
    logic              dclk_q, rdy_pulse, load;
    logic [WORD_W-1:0] word;
    logic              host_q, host_rise;
    logic              buf_bit, buf_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) host_q <= 1'b0;
        else        host_q <= host_clk;
    end
    assign host_rise = host_clk && !host_q;

    fsk_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (tick_hold),
        .tick  (tick)
    );

    fsk_frame_fsm #(.SUBS(SUBS), .DATA_BITS(DATA_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_bit    (fsk_bit),
        .tick_hold (tick_hold),
        .dclk_q    (dclk_q),
        .rdy_pulse (rdy_pulse),
        .load      (load),
        .word      (word)
    );

    fsk_hold_buf #(.W(WORD_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word      (word),
        .host_rise (host_rise),
        .bit_out   (buf_bit),
        .full      (buf_full)
    );

    assign data_out = buf_mode ? buf_bit : fsk_bit;
    assign dclk_out = buf_mode ? 1'b0 : dclk_q;
    assign dclk_oe  = !buf_mode;
    assign rdy_n    = buf_mode ? !buf_full : !rdy_pulse;
endmodule

// File: rtl/fsk_byte_framer_chk.sv
module fsk_byte_framer_chk #(
    parameter int DIV  = 4,
    parameter int SUBS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic buf_mode,
    input logic dclk_out,
    input logic dclk_oe,
    input logic rdy_n,
    input logic host_rise
);
    localparam int HALF_CYC = (SUBS / 2) * DIV;

    int unsigned low_run;
    logic [3:0]  rise_cnt;
    logic        dclk_prev, rdy_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= 0;
            rise_cnt  <= '0;
            dclk_prev <= 1'b0;
            rdy_prev  <= 1'b1;
        end else begin
            dclk_prev <= dclk_out;
            rdy_prev  <= rdy_n;
            low_run   <= (!buf_mode && !rdy_n) ? low_run + 1 : 0;
            if (rdy_prev && !rdy_n)
                rise_cnt <= '0;
            else if (dclk_out && !dclk_prev)
                rise_cnt <= rise_cnt + 1'b1;
        end
    end

    a_r9_no_drive_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        buf_mode |-> (!dclk_oe && !dclk_out));

    a_r3_quiet_during_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && !rdy_n) |-> !dclk_out);

    a_r5_ready_half_bit: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_mode |-> (low_run <= HALF_CYC));

    a_r3_eight_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && rdy_prev && !rdy_n) |-> (rise_cnt == 4'd8));

    a_r7_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && $past(buf_mode) && $rose(rdy_n)) |-> $past(host_rise));
endmodule

bind fsk_byte_framer fsk_byte_framer_chk #(.DIV(DIV), .SUBS(SUBS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_mode  (buf_mode),
    .dclk_out  (dclk_out),
    .dclk_oe   (dclk_oe),
    .rdy_n     (rdy_n),
    .host_rise (host_rise)
);

// File: tb/test_fsk_byte_framer.sv
module test_fsk_byte_framer;
    localparam int DIV  = 4;
    localparam int SUBS = 16;
    localparam int BIT  = SUBS * DIV;
    localparam int HALF = BIT / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsk_bit = 1'b1;
    logic buf_mode = 1'b0;
    logic host_clk = 1'b0;
    logic data_out, dclk_out, dclk_oe, rdy_n;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fsk_byte_framer #(.DIV(DIV), .SUBS(SUBS), .DATA_BITS(8)) i_fsk_byte_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsk_bit  (fsk_bit),
        .buf_mode (buf_mode),
        .host_clk (host_clk),
        .data_out (data_out),
        .dclk_out (dclk_out),
        .dclk_oe  (dclk_oe),
        .rdy_n    (rdy_n)
    );

    function automatic logic [8:0] expect_word(input logic [7:0] b, input logic stop);
        return {stop, b};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor for bit-stream mode
    bit       mon_en = 0;
    logic [7:0] exp_byte = '0;
    longint   cyc = 0;
    longint   rise_cyc = 0, fall_rdy_cyc = 0;
    int       rises = 0, total_rises = 0, pulses = 0;
    logic [7:0] cap = '0;
    logic     dclk_p = 1'b0, rdy_p = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (dclk_out && !dclk_p) begin
                rises++;
                total_rises++;
                cap = {data_out, cap[7:1]};
                rise_cyc = cyc;
            end
            if (!dclk_out && dclk_p)
                check(cyc - rise_cyc == HALF, "R4 clock high width", int'(cyc - rise_cyc), HALF);
            if (!rdy_n && rdy_p) begin
                check(cap == exp_byte, "R3 byte at clock edges", cap, exp_byte);
                check(rises == 8, "R3 edge count", rises, 8);
                check(cyc - rise_cyc == HALF, "R5 ready delay", int'(cyc - rise_cyc), HALF);
                rises = 0;
                pulses++;
                fall_rdy_cyc = cyc;
            end
            if (rdy_n && !rdy_p)
                check(cyc - fall_rdy_cyc == HALF, "R5 ready width", int'(cyc - fall_rdy_cyc), HALF);
        end
        dclk_p = dclk_out;
        rdy_p = rdy_n;
    end

    task automatic drive_bit(input logic v, input bit chk_pass);
        @(negedge clk) fsk_bit = v;
        repeat (HALF) @(negedge clk);
        if (chk_pass) check(data_out == v, "R2 pass-through", data_out, v);
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop, input bit chk_pass);
        exp_byte = b;
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i], chk_pass);
        drive_bit(stop, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
    endtask

    task automatic host_read(output logic v);
        @(negedge clk) host_clk = 1'b1;
        repeat (3) @(negedge clk);
        host_clk = 1'b0;
        repeat (3) @(negedge clk);
        v = data_out;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        buf_mode = mode;
        fsk_bit = 1'b1;
        host_clk = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic read_word(output logic [8:0] w, output logic rdy_after8);
        logic v;
        w = '0;
        rdy_after8 = 1'b1;
        for (int i = 0; i < 9; i++) begin
            host_read(v);
            w[i] = v;
            if (i == 7) rdy_after8 = rdy_n;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] w;
        logic       r8;
        logic [7:0] b;
        logic       s;
        int         p0, t0;
        int unsigned seed;
        seed = $urandom(32'd2024);

        // R1 reset state
        do_reset(1'b0);
        check(rdy_n == 1'b1, "R1 ready idle", rdy_n, 1);
        check(dclk_out == 1'b0, "R1 clock idle", dclk_out, 0);
        check(dclk_oe == 1'b1, "R1 clock enable", dclk_oe, 1);
        check(data_out == 1'b1, "R1 data idle", data_out, 1);

        // bit-stream mode: directed then random (R2 R3 R4 R5)
        mon_en = 1;
        send_frame(8'h00, 1'b1, 1'b1);
        send_frame(8'hFF, 1'b1, 1'b1);
        send_frame(8'hA5, 1'b1, 1'b1);
        for (int n = 0; n < 20; n++) begin
            b = 8'($urandom);
            send_frame(b, 1'b1, 1'b1);
        end
        check(pulses == 23, "R3 one ready per byte", pulses, 23);

        // R6 false start glitch
        p0 = pulses;
        t0 = total_rises;
        @(negedge clk) fsk_bit = 1'b0;
        repeat (HALF / 2) @(negedge clk);
        fsk_bit = 1'b1;
        repeat (12 * BIT) @(negedge clk);
        check(pulses == p0, "R6 no ready on glitch", pulses, p0);
        check(total_rises == t0, "R6 no clock on glitch", total_rises, t0);
        send_frame(8'h3C, 1'b1, 1'b1);
        check(pulses == p0 + 1, "R6 recovers after glitch", pulses, p0 + 1);
        mon_en = 0;

        // buffered mode
        do_reset(1'b1);
        check(dclk_oe == 1'b0, "R9 clock not driven", dclk_oe, 0);
        check(rdy_n == 1'b1, "R7 empty after reset", rdy_n, 1);
        for (int n = 0; n < 8; n++) begin
            b = (n == 0) ? 8'h81 : 8'($urandom);
            s = (n == 3) ? 1'b0 : 1'b1;
            send_frame(b, s, 1'b0);
            check(rdy_n == 1'b0, "R7 ready after store", rdy_n, 0);
            check(dclk_out == 1'b0, "R9 clock held low", dclk_out, 0);
            read_word(w, r8);
            check(w == expect_word(b, s), "R8 word read out", w, expect_word(b, s));
            check(r8 == 1'b0, "R7 ready held through eight reads", r8, 0);
            check(rdy_n == 1'b1, "R7 ready released on ninth", rdy_n, 1);
        end

        // R10 replace a partly read word
        send_frame(8'h5A, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) host_read(s);
        send_frame(8'hC3, 1'b1, 1'b0);
        read_word(w, r8);
        check(w == expect_word(8'hC3, 1'b1), "R10 replacement word", w, expect_word(8'hC3, 1'b1));
        check(rdy_n == 1'b1, "R10 released after replacement", rdy_n, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule